// File: doc/BRIEF.md
# Serial Front-End Control Slave

This block is the receiving end of a two-wire clocked control bus of the kind used to steer radio front-end parts such as amplifiers, switches and tuners. A master drives a serial clock and a bidirectional data line. The slave watches for a start condition and decodes the command header that follows. It then carries out one of three operations: a full register write, a register read, or a compact write that reaches only register 0. It keeps a file of 32 eight-bit registers and presents every register on a flat parallel output, so the surrounding logic can use the values directly as control lines.

Each slave has a 4-bit bus identity. Address 0 is shared by all slaves, which lets one telegram set up every part on the bus at once. The top three registers hold fixed identification values that software can read but cannot overwrite. Both serial inputs pass through a two-flop synchronizer into the system clock domain. Every bus event is taken from the synchronized clock edges.

Top module: `fec_slave`

## Requirements
- R1: After reset, registers 0 to 28 read 0x00, register 29 reads ID_A (0xA5), register 30 reads ID_B (0x3C), register 31 reads the slave identity in its low four bits (0x06), and `sdata_oe` is 0.
- R2: A start condition is sdata rising and then falling while sclk is low. It is followed by a header of 4 identity bits, then 8 command bits, then an odd parity bit, all sent MSB first and sampled on falling sclk edges. Command `010aaaaa` to this slave's identity, followed by 8 data bits, an odd parity bit and one park bit, loads register `aaaaa`. No other register changes.
- R3: A header sent to identity 0 (broadcast) is accepted for writes in the same way as one sent to the slave's own identity.
- R4: Frames sent to any other non-zero identity change no register and never cause the slave to drive the data line.
- R5: Command `1ddddddd` (the short register-0 write, with no data frame) copies `ddddddd` into bits 6:0 of register 0 and leaves bit 7 unchanged.
- R6: A header whose parity makes its one-count even is discarded entirely: no register changes and no read response follows.
- R7: A data frame whose parity makes its one-count even is discarded, and the addressed register keeps its value.
- R8: Command `011aaaaa` to the slave's own identity is followed by one park cycle driven by the master. The slave then drives 8 bits of register `aaaaa`, MSB first, and an odd parity bit, one bit per sclk cycle, with `sdata_oe` high. It drives one low park cycle and then releases the line.
- R9: A read command sent to the broadcast identity is ignored, and the slave never drives the line.
- R10: Registers 29 to 31 are read-only. Writes to them are ignored, and reads return their fixed values.
- R11: A start condition in the middle of a frame abandons that frame, and decoding restarts with a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which must run several times faster than sclk |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bus clock from the master |
| sdata_i | input | 1 | Serial data line as seen at the pad |
| sdata_o | output | 1 | Serial data driven by the slave during a read |
| sdata_oe | output | 1 | Output enable for sdata_o |
| regs_o | output | 256 | All 32 registers, register n at bits n*8+7:n*8 |

## Verification
Both serial inputs cross two synchronizer flops and one edge register before the slave acts on them. A register write therefore appears on `regs_o` about four system clocks after the falling sclk edge that carries the last parity bit. A read bit appears on `sdata_o` about four clocks after the rising sclk edge that opens its cycle. The bench keeps each sclk half-period at eight system clocks. It samples read bits just before the falling edge and compares the register file only after the trailing park cycle, so every result has settled well before it is observed. The same rule covers frames that must be ignored: the full register file is compared after such a frame, and `sdata_oe` is monitored throughout read windows that must stay silent.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RTURN,
    ST_RDATA,
    ST_REND
  } fec_state_e;

  // Upper three command bits for the full-length operations
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_READ  = 3'b011;

  // Odd parity: value that makes the total count of ones odd
  function automatic logic odd_bit(input logic [15:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/fec_bus_sampler.sv
module fec_bus_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic bit_val,
  output logic start_evt
);

  logic [1:0] ck_sy, dt_sy;
  logic       ck_q, dt_q, armed;
  logic       dt_rise_lo, dt_fall_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sy <= '0;
      dt_sy <= '0;
      ck_q  <= 1'b0;
      dt_q  <= 1'b0;
    end else begin
      ck_sy <= {ck_sy[0], sclk_i};
      dt_sy <= {dt_sy[0], sdata_i};
      ck_q  <= ck_sy[1];
      dt_q  <= dt_sy[1];
    end
  end

  assign sclk_rise  = ck_sy[1] & ~ck_q;
  assign sclk_fall  = ~ck_sy[1] & ck_q;
  assign bit_val    = dt_sy[1];
  assign dt_rise_lo = dt_sy[1] & ~dt_q & ~ck_sy[1] & ~ck_q;
  assign dt_fall_lo = ~dt_sy[1] & dt_q & ~ck_sy[1] & ~ck_q;

  // A rising data edge while the clock is low arms the detector, and the falling data edge that follows completes the start
  always_ff @(posedge clk) begin
    if (rst)             armed <= 1'b0;
    else if (ck_sy[1])   armed <= 1'b0;
    else if (dt_rise_lo) armed <= 1'b1;
    else if (dt_fall_lo) armed <= 1'b0;
  end

  assign start_evt = dt_fall_lo & armed;

  a_r11_start_on_low_clock: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> (!sclk_rise && !sclk_fall));

endmodule

// File: rtl/fec_frame_engine.sv
module fec_frame_engine
  import fec_pkg::*;
#(
  parameter int SW = 4,
  parameter int AW = 5,
  parameter int DW = 8,
  parameter logic [SW-1:0] SLAVE_ID = 4'h6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          bit_val,
  input  logic          start_evt,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          r0_en,
  output logic [AW+1:0] r0_data,
  output logic          sdata_o,
  output logic          sdata_oe
);

  localparam int CW   = AW + 3;
  localparam int HW   = SW + CW;
  localparam int CNTW = $clog2(HW + 1);
  localparam logic [CNTW-1:0] HW_C = CNTW'(HW);
  localparam logic [CNTW-1:0] DW_C = CNTW'(DW);

  fec_state_e      state;
  logic [CNTW-1:0] cnt;
  logic [HW-1:0]   hdr;
  logic [DW-1:0]   dsh;
  logic [DW:0]     tx;
  logic [SW-1:0]   sa_q;

  logic [SW-1:0] hdr_sa;
  logic [2:0]    hdr_op;
  logic          hdr_ok, dat_ok;

  assign hdr_sa = hdr[HW-1 -: SW];
  assign hdr_op = hdr[CW-1 -: 3];
  assign hdr_ok = (^{hdr, bit_val}) && ((hdr_sa == SLAVE_ID) || (hdr_sa == '0));
  assign dat_ok = ^{dsh, bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      hdr      <= '0;
      dsh      <= '0;
      tx       <= '0;
      sa_q     <= '0;
      reg_addr <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      r0_en    <= 1'b0;
      r0_data  <= '0;
      sdata_o  <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      r0_en <= 1'b0;
      if (start_evt) begin
        state    <= ST_CMD;
        cnt      <= '0;
        sdata_o  <= 1'b0;
        sdata_oe <= 1'b0;
      end else begin
        case (state)
          ST_CMD: if (sclk_fall) begin
            if (cnt != HW_C) begin
              hdr <= {hdr[HW-2:0], bit_val};
              cnt <= cnt + 1'b1;
            end else begin
              cnt      <= '0;
              sa_q     <= hdr_sa;
              reg_addr <= hdr[AW-1:0];
              state    <= ST_IDLE;
              if (hdr_ok) begin
                if (hdr[CW-1]) begin
                  r0_en   <= 1'b1;
                  r0_data <= hdr[CW-2:0];
                end else if (hdr_op == OP_WRITE) begin
                  state <= ST_WDATA;
                end else if (hdr_op == OP_READ && hdr_sa == SLAVE_ID) begin
                  state <= ST_RTURN;
                end
              end
            end
          end
          ST_WDATA: if (sclk_fall) begin
            if (cnt != DW_C) begin
              dsh <= {dsh[DW-2:0], bit_val};
              cnt <= cnt + 1'b1;
            end else begin
              cnt   <= '0;
              state <= ST_IDLE;
              if (dat_ok) begin
                wr_en   <= 1'b1;
                wr_data <= dsh;
              end
            end
          end
          ST_RTURN: if (sclk_fall) begin
            tx    <= {rd_data, ~^rd_data};
            cnt   <= '0;
            state <= ST_RDATA;
          end
          ST_RDATA: begin
            if (sclk_rise) begin
              sdata_oe <= 1'b1;
              sdata_o  <= tx[DW];
            end else if (sclk_fall) begin
              tx <= {tx[DW-1:0], 1'b0};
              if (cnt == DW_C) begin
                cnt   <= '0;
                state <= ST_REND;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_REND: begin
            if (sclk_rise) begin
              sdata_o <= 1'b0;
            end else if (sclk_fall) begin
              sdata_oe <= 1'b0;
              state    <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r9_drive_only_own_id: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) |-> (sa_q == SLAVE_ID));

  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_CMD) |-> !sdata_oe);

  a_r7_write_after_data: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(state) == ST_WDATA);

endmodule

// File: rtl/fec_reg_bank.sv
module fec_reg_bank #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int SW = 4,
  parameter int R0W = 7,
  parameter logic [SW-1:0] SLAVE_ID = 4'h6,
  parameter logic [DW-1:0] ID_A = 8'hA5,
  parameter logic [DW-1:0] ID_B = 8'h3C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             r0_en,
  input  logic [R0W-1:0]   r0_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [(1<<AW)*DW-1:0] regs_flat
);

  localparam int NREG    = 1 << AW;
  localparam int RO_BASE = NREG - 3;

  logic [DW-1:0] mem  [RO_BASE];
  logic [DW-1:0] view [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RO_BASE; i++) mem[i] <= '0;
    end else if (r0_en) begin
      mem[0] <= {mem[0][DW-1:R0W], r0_data};
    end else if (wr_en && (wr_addr < AW'(RO_BASE))) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    if (g < RO_BASE) begin : g_rw
      assign view[g] = mem[g];
    end else if (g == RO_BASE) begin : g_ida
      assign view[g] = ID_A;
    end else if (g == RO_BASE + 1) begin : g_idb
      assign view[g] = ID_B;
    end else begin : g_sid
      assign view[g] = {{(DW-SW){1'b0}}, SLAVE_ID};
    end
    assign regs_flat[g*DW +: DW] = view[g];
  end

  assign rd_data = view[rd_addr];

  a_r5_reg0_top_bit_kept: assert property (@(posedge clk) disable iff (rst)
    r0_en |=> mem[0][DW-1] == $past(mem[0][DW-1]));

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !r0_en) |=> $stable(regs_flat));

  a_r10_ro_write_no_effect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= AW'(RO_BASE)) |=> $stable(regs_flat));

endmodule

// File: rtl/fec_slave.sv
module fec_slave #(
  parameter int SW = 4,
  parameter int AW = 5,
  parameter int DW = 8,
  parameter logic [SW-1:0] SLAVE_ID = 4'h6,
  parameter logic [DW-1:0] ID_A = 8'hA5,
  parameter logic [DW-1:0] ID_B = 8'h3C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  output logic                  sdata_o,
  output logic                  sdata_oe,
  output logic [(1<<AW)*DW-1:0] regs_o
);

  // The short write carries AW+2 data bits and requires DW > AW+2
  localparam int R0W = AW + 2;

  logic          sclk_rise, sclk_fall, bit_val, start_evt;
  logic [AW-1:0] reg_addr;
  logic          wr_en, r0_en;
  logic [DW-1:0] wr_data, rd_data;
  logic [R0W-1:0] r0_data;

  fec_bus_sampler u_smp (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sclk_i),
    .sdata_i   (sdata_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .bit_val   (bit_val),
    .start_evt (start_evt)
  );

  fec_frame_engine #(.SW(SW), .AW(AW), .DW(DW), .SLAVE_ID(SLAVE_ID)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .bit_val   (bit_val),
    .start_evt (start_evt),
    .rd_data   (rd_data),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .r0_en     (r0_en),
    .r0_data   (r0_data),
    .sdata_o   (sdata_o),
    .sdata_oe  (sdata_oe)
  );

  fec_reg_bank #(.AW(AW), .DW(DW), .SW(SW), .R0W(R0W), .SLAVE_ID(SLAVE_ID),
                 .ID_A(ID_A), .ID_B(ID_B)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (reg_addr),
    .wr_data   (wr_data),
    .r0_en     (r0_en),
    .r0_data   (r0_data),
    .rd_addr   (reg_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: tb/sim_fec_slave.sv
module sim_fec_slave;

  localparam logic [3:0] MYID = 4'h6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic mst_d = 1'b0;
  logic sdata_o, sdata_oe;
  logic [255:0] regs_o;
  wire  sdata_line = sdata_oe ? sdata_o : mst_d;

  int checks = 0;
  int fails = 0;
  logic [7:0] expv [32];
  logic [8:0] rd_bits;
  int rd_oe_hits;
  int oe_stray;

  always #2.5 clk = ~clk;

  fec_slave u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata_line),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .regs_o(regs_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expd);
    checks++;
    if (act !== expd) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) check(req, 32'(regs_o[i*8 +: 8]), 32'(expv[i]));
  endtask

  task automatic sstart();
    sclk = 1'b0; mst_d = 1'b0; wait_n(4);
    mst_d = 1'b1; wait_n(4);
    mst_d = 1'b0; wait_n(4);
  endtask

  task automatic sbit(input logic b);
    sclk = 1'b1; wait_n(1);
    mst_d = b; wait_n(7);
    sclk = 1'b0; wait_n(8);
  endtask

  task automatic send_hdr(input logic [3:0] sa, input logic [7:0] cmd, input logic flip);
    logic [11:0] h;
    h = {sa, cmd};
    for (int i = 11; i >= 0; i--) sbit(h[i]);
    sbit((~^h) ^ flip);
  endtask

  task automatic wr(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d,
                    input logic fc, input logic fd);
    sstart();
    send_hdr(sa, {3'b010, a}, fc);
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    sbit((~^d) ^ fd);
    sbit(1'b0);
    if (!fc && !fd && (sa == MYID || sa == 4'h0) && a < 5'd29) expv[a] = d;
    wait_n(4);
  endtask

  task automatic r0w(input logic [3:0] sa, input logic [6:0] d, input logic fc);
    sstart();
    send_hdr(sa, {1'b1, d}, fc);
    sbit(1'b0);
    if (!fc && (sa == MYID || sa == 4'h0)) expv[0] = {expv[0][7], d};
    wait_n(4);
  endtask

  task automatic rd(input logic [3:0] sa, input logic [4:0] a, input logic fc);
    sstart();
    send_hdr(sa, {3'b011, a}, fc);
    sbit(1'b0);
    rd_oe_hits = 0;
    for (int i = 8; i >= 0; i--) begin
      sclk = 1'b1; wait_n(8);
      rd_bits[i] = sdata_o;
      if (sdata_oe) rd_oe_hits++;
      sclk = 1'b0; wait_n(8);
    end
    sclk = 1'b1; wait_n(8);
    sclk = 1'b0; wait_n(8);
    wait_n(4);
  endtask

  always @(posedge clk) if (!rst && sdata_oe) oe_stray++;

  initial begin
    oe_stray = 0;
    for (int i = 0; i < 29; i++) expv[i] = 8'h00;
    expv[29] = 8'hA5; expv[30] = 8'h3C; expv[31] = {4'h0, MYID};
    wait_n(5); rst = 1'b0; wait_n(4);

    // R1 reset state
    check_all("R1");
    check("R1 oe", 32'(sdata_oe), 32'd0);

    // R2 + R10: write every address with own identity
    for (int a = 0; a < 32; a++) wr(MYID, 5'(a), 8'((a * 37 + 11) & 255), 1'b0, 1'b0);
    check_all("R2 R10");

    // R3 broadcast writes
    for (int a = 0; a < 32; a += 3) wr(4'h0, 5'(a), 8'((a * 91 + 200) & 255), 1'b0, 1'b0);
    check_all("R3");

    // R4 other identities ignored
    for (int s = 1; s < 16; s++)
      if (4'(s) != MYID) wr(4'(s), 5'(s), 8'(8'hFF ^ s), 1'b0, 1'b0);
    check_all("R4");
    check("R4 oe", 32'(oe_stray), 32'd0);

    // R5 short register-0 write keeps bit 7
    wr(MYID, 5'd0, 8'h80, 1'b0, 1'b0);
    r0w(MYID, 7'h55, 1'b0); check("R5", 32'(regs_o[7:0]), 32'h00D5);
    r0w(MYID, 7'h00, 1'b0); check("R5", 32'(regs_o[7:0]), 32'h0080);
    wr(MYID, 5'd0, 8'h00, 1'b0, 1'b0);
    r0w(4'h0, 7'h7F, 1'b0); check("R5 R3", 32'(regs_o[7:0]), 32'h007F);
    r0w(4'h9, 7'h01, 1'b0); check("R5 R4", 32'(regs_o[7:0]), 32'h007F);
    check_all("R5");

    // R6 header parity error
    wr(MYID, 5'd4, 8'h5A, 1'b1, 1'b0);
    r0w(MYID, 7'h11, 1'b1);
    check_all("R6");
    // R7 data parity error
    wr(MYID, 5'd7, 8'hC3, 1'b0, 1'b1);
    wr(4'h0, 5'd8, 8'h3C, 1'b0, 1'b1);
    check_all("R7");

    // R8 + R10: read back every register
    oe_stray = 0;
    for (int a = 0; a < 32; a++) begin
      rd(MYID, 5'(a), 1'b0);
      check("R8 R10 data", 32'(rd_bits), 32'({expv[a], ~^expv[a]}));
      check("R8 oe", 32'(rd_oe_hits), 32'd9);
      check("R8 release", 32'(sdata_oe), 32'd0);
    end

    // R9 broadcast read, R4 foreign read, R6 bad header read: no drive
    oe_stray = 0;
    rd(4'h0, 5'd3, 1'b0);
    check("R9", 32'(oe_stray), 32'd0);
    rd(4'h2, 5'd3, 1'b0);
    check("R4 read", 32'(oe_stray), 32'd0);
    rd(MYID, 5'd3, 1'b1);
    check("R6 read", 32'(oe_stray), 32'd0);

    // R11 start in the middle of a frame restarts decoding
    sstart();
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b0);
    wr(MYID, 5'd12, 8'hE7, 1'b0, 1'b0);
    check("R11", 32'(regs_o[12*8 +: 8]), 32'h00E7);
    check_all("R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule